// File: doc/BRIEF.md
# Serial Receive Character Buffer with Error Tracking

This block is the storage stage behind an asynchronous serial receiver's deserializer. Each cycle the deserializer may report a finished character together with three error flags: parity, framing and break. It may also raise a separate strobe when it sees a valid start bit. The buffer queues finished characters with their flags and shows the oldest one to the host. It reports whether data is waiting, whether the queue is full, and which errors apply. The host selects the usable depth: 8 or 16 entries.

When the queue is full, one more character can wait in a single holding stage. It moves into the queue in the same cycle that a read frees a slot. If a further character finishes while that stage is occupied, it replaces the waiting character, and the overrun flag latches at the start bit of the new character. The block can also drive an active-low request-to-send line that blocks the far transmitter while the queue is full.

The host controls the receiver with four one-cycle commands: enable, disable, receiver reset and error reset. Configuration selects how the error flags are reported. In per-character mode they describe the head entry. In accumulated mode they are ORed over every entry that has reached the head.

Top module: `uart_rx_fifo`

## Requirements
- R1: With `cfg_deep`=0 the queue holds 8 characters and with `cfg_deep`=1 it holds 16. `st_full` is 1 exactly when the stored count equals the selected depth.
- R2: `st_ready` is 1 whenever at least one character is stored. `irq` equals `st_ready` when `cfg_irq_full`=0 and equals `st_full` when `cfg_irq_full`=1.
- R3: Each entry keeps the 8-bit character and its three flags. With `cfg_block_err`=0, `rd_char` and the flags show the head entry: `st_perr` is the parity flag, `st_ferr` the framing flag and `st_brk` the break flag. All of them read 0 when the queue is empty.
- R4: With `cfg_block_err`=1, each flag output is the OR of that flag over every entry that has become head since the last `cmd_err_reset`. Entries still waiting behind the head do not count. `cmd_err_reset` clears these accumulated flags and also clears `st_overrun`.
- R5: Only a `rd_data` pulse removes the head entry. Status outputs never change the queue, and `rd_data` on an empty queue has no effect.
- R6: A character that finishes while the queue is full, with no read in that cycle, waits in the holding stage. It enters the queue in the cycle a read frees a slot, so the queue stays full across that read.
- R7: If a character finishes while the holding stage is occupied and no slot is free, it replaces the waiting character and the queue is unchanged. `st_overrun` is set one cycle after a `start_bit` that arrives while the waiting character cannot move. It stays set until an error reset or a receiver reset.
- R8: With `cfg_auto_rts`=1, `rts_n` goes to 1 after a `start_bit` that arrives while the queue is full and no read occurs. It returns to 0 in the cycle after the queue stops being full. With `cfg_auto_rts`=0, `rts_n` is 0.
- R9: `cmd_disable` stops reception from the next cycle on and drops any waiting character. Stored entries stay readable. Finished characters and start bits are ignored until `cmd_enable`, and reception resumes with the next character after that.
- R10: `cmd_rx_reset`, and the synchronous `rst`, empty the queue and clear all status, the overrun flag, `rts_n`, `irq` and the enable. No character is accepted until `cmd_enable`.
- R11: A finished character and a read in the same cycle keep the stored count unchanged, and the queue keeps its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_enable | input | 1 | Enable-receiver command pulse |
| cmd_disable | input | 1 | Disable-receiver command pulse |
| cmd_rx_reset | input | 1 | Receiver reset command pulse |
| cmd_err_reset | input | 1 | Error reset command pulse |
| cfg_deep | input | 1 | 1: depth 16, 0: depth 8 |
| cfg_block_err | input | 1 | 1: accumulated flags, 0: head flags |
| cfg_irq_full | input | 1 | 1: irq follows full, 0: irq follows ready |
| cfg_auto_rts | input | 1 | Enable automatic request-to-send |
| start_bit | input | 1 | Valid start bit seen by the deserializer |
| char_valid | input | 1 | A character has finished |
| char_data | input | 8 | Finished character |
| char_perr | input | 1 | Parity error of finished character |
| char_ferr | input | 1 | Framing error of finished character |
| char_brk | input | 1 | Break received with finished character |
| rd_data | input | 1 | Read pulse: removes the head entry |
| rd_char | output | 8 | Head character, 0 when empty |
| st_ready | output | 1 | At least one character stored |
| st_full | output | 1 | Selected depth reached |
| st_perr | output | 1 | Reported parity error |
| st_ferr | output | 1 | Reported framing error |
| st_brk | output | 1 | Reported break |
| st_overrun | output | 1 | Overrun latched |
| rx_enabled | output | 1 | Receiver enabled |
| irq | output | 1 | Interrupt request |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
Both depths are filled from empty to full, and the full flag is checked at each step. A wrong depth decode would assert full one entry early or late. Accumulated mode is driven with flag patterns whose OR grows only as entries reach the head. An implementation that ORs over the whole queue would report every error as soon as the first character arrives. A read while the holding stage is occupied must leave the queue full, and a replaced waiting character must drop out of the read order. A design that stalls the waiting character one cycle, or keeps the older one, gives a different count or data order. Disable with a waiting character and receiver reset are checked through the read order and ready flag: a leaked waiting character or an ignored reset shows up as an extra entry.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;

    localparam int RX_DATA_W = 8;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_flags_t;

    typedef struct packed {
        rx_flags_t              flags;
        logic [RX_DATA_W-1:0]   data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        OCC_IDLE = 2'b00,
        OCC_POP  = 2'b01,
        OCC_PUSH = 2'b10,
        OCC_BOTH = 2'b11
    } occ_op_t;

    function automatic rx_flags_t merge_flags(input rx_flags_t a, input rx_flags_t b);
        rx_flags_t r;
        r.brk  = a.brk  | b.brk;
        r.ferr = a.ferr | b.ferr;
        r.perr = a.perr | b.perr;
        return r;
    endfunction

    function automatic rx_flags_t gate_flags(input rx_flags_t a, input logic en);
        rx_flags_t r;
        r.brk  = a.brk  & en;
        r.ferr = a.ferr & en;
        r.perr = a.perr & en;
        return r;
    endfunction

endpackage

// File: rtl/uart_rx_fifo_store.sv
module uart_rx_fifo_store
    import uart_rx_fifo_pkg::*;
#(
    parameter int MAX_DEPTH   = 16,
    parameter int SMALL_DEPTH = 8,
    localparam int PW = $clog2(MAX_DEPTH),
    localparam int CW = $clog2(MAX_DEPTH + 1)
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            deep,
    input  logic            push,
    input  rx_entry_t       push_entry,
    input  logic            pop_req,
    output rx_entry_t       head,
    output logic [CW-1:0]   count,
    output logic            nonempty,
    output logic            full,
    output logic            full_next,
    output logic            pop_ok,
    output logic            space
);

    rx_entry_t          mem [MAX_DEPTH];
    logic [PW-1:0]      wr_ptr;
    logic [PW-1:0]      rd_ptr;
    logic [CW-1:0]      count_n;
    logic [CW-1:0]      depth_sel;
    occ_op_t            op;

    assign depth_sel = deep ? CW'(MAX_DEPTH) : CW'(SMALL_DEPTH);
    assign nonempty  = (count != '0);
    assign full      = (count >= depth_sel);
    assign pop_ok    = pop_req & nonempty & ~clear;
    assign space     = ~full | pop_ok;
    assign head      = mem[rd_ptr];
    assign op        = occ_op_t'({push, pop_ok});

    always_comb begin
        unique case (op)
            OCC_PUSH: count_n = count + CW'(1);
            OCC_POP:  count_n = count - CW'(1);
            default:  count_n = count;
        endcase
        if (clear) count_n = '0;
    end

    assign full_next = (count_n >= depth_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_n;
            if (clear) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push)   wr_ptr <= wr_ptr + PW'(1);
                if (pop_ok) rd_ptr <= rd_ptr + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem[wr_ptr] <= push_entry;
    end

endmodule

// File: rtl/uart_rx_fifo_intake.sv
module uart_rx_fifo_intake
    import uart_rx_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic        clr_all,
    input  logic        err_clr,
    input  logic        start_bit,
    input  logic        char_valid,
    input  rx_entry_t   char_in,
    input  logic        space,
    output logic        push,
    output rx_entry_t   push_entry,
    output logic        hold_valid,
    output logic        overrun
);

    rx_entry_t  hold_q, hold_d;
    logic       hold_vd;
    logic       in_ok;
    logic       ovr_set;

    assign in_ok   = accept & char_valid;
    assign ovr_set = accept & start_bit & hold_valid & ~space;

    always_comb begin
        push       = 1'b0;
        push_entry = hold_q;
        hold_d     = hold_q;
        hold_vd    = hold_valid;
        if (!accept) begin
            hold_vd = 1'b0;
        end else if (hold_valid) begin
            if (space) push = 1'b1;
            if (in_ok) begin
                hold_d  = char_in;
                hold_vd = 1'b1;
            end else if (space) begin
                hold_vd = 1'b0;
            end
        end else if (in_ok) begin
            if (space) begin
                push       = 1'b1;
                push_entry = char_in;
            end else begin
                hold_d  = char_in;
                hold_vd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_q     <= '0;
            overrun    <= 1'b0;
        end else begin
            hold_valid <= hold_vd;
            hold_q     <= hold_d;
            if (clr_all)      overrun <= 1'b0;
            else if (ovr_set) overrun <= 1'b1;
            else if (err_clr) overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_fifo_status.sv
module uart_rx_fifo_status
    import uart_rx_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr_all,
    input  logic        err_clr,
    input  logic        block_mode,
    input  rx_flags_t   head_flags,
    input  logic        nonempty,
    input  logic        pop_ok,
    output rx_flags_t   flags_out
);

    rx_flags_t  sticky;
    rx_flags_t  fresh;
    rx_flags_t  sticky_base;
    logic       head_seen;
    logic       absorb;

    assign absorb      = nonempty & ~head_seen;
    assign fresh       = gate_flags(head_flags, absorb);
    assign sticky_base = gate_flags(sticky, ~err_clr);

    always_comb begin
        if (block_mode) flags_out = merge_flags(sticky, fresh);
        else            flags_out = gate_flags(head_flags, nonempty);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            sticky    <= '0;
            head_seen <= 1'b0;
        end else begin
            sticky <= merge_flags(sticky_base, fresh);
            if (pop_ok)        head_seen <= 1'b0;
            else if (nonempty) head_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_fifo_pkg::*;
#(
    parameter int MAX_DEPTH   = 16,
    parameter int SMALL_DEPTH = 8
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_enable,
    input  logic                    cmd_disable,
    input  logic                    cmd_rx_reset,
    input  logic                    cmd_err_reset,
    input  logic                    cfg_deep,
    input  logic                    cfg_block_err,
    input  logic                    cfg_irq_full,
    input  logic                    cfg_auto_rts,
    input  logic                    start_bit,
    input  logic                    char_valid,
    input  logic [RX_DATA_W-1:0]    char_data,
    input  logic                    char_perr,
    input  logic                    char_ferr,
    input  logic                    char_brk,
    input  logic                    rd_data,
    output logic [RX_DATA_W-1:0]    rd_char,
    output logic                    st_ready,
    output logic                    st_full,
    output logic                    st_perr,
    output logic                    st_ferr,
    output logic                    st_brk,
    output logic                    st_overrun,
    output logic                    rx_enabled,
    output logic                    irq,
    output logic                    rts_n
);

    localparam int CW = $clog2(MAX_DEPTH + 1);

    rx_entry_t      char_in;
    rx_entry_t      push_entry;
    rx_entry_t      head;
    rx_flags_t      flags_out;
    logic [CW-1:0]  count;
    logic           accept;
    logic           push;
    logic           pop_ok;
    logic           space;
    logic           nonempty;
    logic           full;
    logic           full_next;
    logic           hold_valid;
    logic           rts_hi;

    assign char_in.data       = char_data;
    assign char_in.flags.perr = char_perr;
    assign char_in.flags.ferr = char_ferr;
    assign char_in.flags.brk  = char_brk;

    assign accept = rx_enabled & ~cmd_disable & ~cmd_rx_reset;

    always_ff @(posedge clk) begin
        if (rst || cmd_rx_reset || cmd_disable) rx_enabled <= 1'b0;
        else if (cmd_enable)                    rx_enabled <= 1'b1;
    end

    uart_rx_fifo_intake u_intake (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .clr_all    (cmd_rx_reset),
        .err_clr    (cmd_err_reset),
        .start_bit  (start_bit),
        .char_valid (char_valid),
        .char_in    (char_in),
        .space      (space),
        .push       (push),
        .push_entry (push_entry),
        .hold_valid (hold_valid),
        .overrun    (st_overrun)
    );

    uart_rx_fifo_store #(
        .MAX_DEPTH   (MAX_DEPTH),
        .SMALL_DEPTH (SMALL_DEPTH)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .clear      (cmd_rx_reset),
        .deep       (cfg_deep),
        .push       (push),
        .push_entry (push_entry),
        .pop_req    (rd_data),
        .head       (head),
        .count      (count),
        .nonempty   (nonempty),
        .full       (full),
        .full_next  (full_next),
        .pop_ok     (pop_ok),
        .space      (space)
    );

    uart_rx_fifo_status u_status (
        .clk        (clk),
        .rst        (rst),
        .clr_all    (cmd_rx_reset),
        .err_clr    (cmd_err_reset),
        .block_mode (cfg_block_err),
        .head_flags (head.flags),
        .nonempty   (nonempty),
        .pop_ok     (pop_ok),
        .flags_out  (flags_out)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd_rx_reset)
            rts_hi <= 1'b0;
        else
            rts_hi <= cfg_auto_rts & full_next & (rts_hi | (accept & start_bit & full));
    end

    assign rd_char  = nonempty ? head.data : '0;
    assign st_ready = nonempty;
    assign st_full  = full;
    assign st_perr  = flags_out.perr;
    assign st_ferr  = flags_out.ferr;
    assign st_brk   = flags_out.brk;
    assign irq      = cfg_irq_full ? full : nonempty;
    assign rts_n    = rts_hi;

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
    parameter int MAX_DEPTH = 16,
    localparam int CW = $clog2(MAX_DEPTH + 1)
)(
    input logic             clk,
    input logic             rst,
    input logic             cmd_disable,
    input logic             cmd_rx_reset,
    input logic             cfg_deep,
    input logic             cfg_auto_rts,
    input logic             start_bit,
    input logic             rd_data,
    input logic             st_ready,
    input logic             st_full,
    input logic             st_overrun,
    input logic             rx_enabled,
    input logic             irq,
    input logic             rts_n,
    input logic [CW-1:0]    count,
    input logic             hold_valid,
    input logic             push
);

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(MAX_DEPTH));

    a_r1_full_has_data: assert property (@(posedge clk) disable iff (rst)
        st_full |-> st_ready);

    a_r5_no_pop_keeps_data: assert property (@(posedge clk) disable iff (rst)
        st_ready && !rd_data && !cmd_rx_reset |=> st_ready);

    a_r6_held_moves_in: assert property (@(posedge clk) disable iff (rst)
        hold_valid && !st_full && !cmd_disable && !cmd_rx_reset |-> push);

    a_r7_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(st_overrun) |-> $past(start_bit) && $past(hold_valid));

    a_r8_rts_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_auto_rts |=> !rts_n);

    a_r8_rts_only_full: assert property (@(posedge clk) disable iff (rst)
        rts_n && $stable(cfg_deep) |-> st_full);

    a_r9_disable_drops: assert property (@(posedge clk) disable iff (rst)
        cmd_disable |=> !rx_enabled && !hold_valid);

    a_r9_push_needs_enable: assert property (@(posedge clk) disable iff (rst)
        push |-> rx_enabled);

    a_r10_rx_reset_clears: assert property (@(posedge clk) disable iff (rst)
        cmd_rx_reset |=> !st_ready && !rx_enabled && !st_overrun && !rts_n && !irq);

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.MAX_DEPTH(MAX_DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_disable  (cmd_disable),
    .cmd_rx_reset (cmd_rx_reset),
    .cfg_deep     (cfg_deep),
    .cfg_auto_rts (cfg_auto_rts),
    .start_bit    (start_bit),
    .rd_data      (rd_data),
    .st_ready     (st_ready),
    .st_full      (st_full),
    .st_overrun   (st_overrun),
    .rx_enabled   (rx_enabled),
    .irq          (irq),
    .rts_n        (rts_n),
    .count        (count),
    .hold_valid   (hold_valid),
    .push         (push)
);

// File: tb/uart_rx_fifo_test.sv
module uart_rx_fifo_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_enable = 0, cmd_disable = 0, cmd_rx_reset = 0, cmd_err_reset = 0;
    logic       cfg_deep = 0, cfg_block_err = 0, cfg_irq_full = 0, cfg_auto_rts = 0;
    logic       start_bit = 0, char_valid = 0, rd_data = 0;
    logic [7:0] char_data = 0;
    logic       char_perr = 0, char_ferr = 0, char_brk = 0;
    logic [7:0] rd_char;
    logic       st_ready, st_full, st_perr, st_ferr, st_brk, st_overrun;
    logic       rx_enabled, irq, rts_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    uart_rx_fifo uut (.*);

    function automatic int fdata(input int i);
        return (i * 37 + 5) % 256;
    endfunction

    function automatic int fflags(input int i);
        return (i ^ (i >> 2)) & 7;
    endfunction

    function automatic int fl();
        return int'({st_brk, st_ferr, st_perr});
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cmd_enable = 0; cmd_disable = 0; cmd_rx_reset = 0; cmd_err_reset = 0;
        start_bit = 0; char_valid = 0; rd_data = 0;
    endtask

    task automatic send(input int i);
        char_valid = 1;
        char_data  = 8'(fdata(i));
        {char_brk, char_ferr, char_perr} = 3'(fflags(i));
        step();
    endtask

    task automatic pop();
        rd_data = 1;
        step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        // R10: state after reset
        chk("R10 ready", st_ready, 0);
        chk("R10 full", st_full, 0);
        chk("R10 enabled", rx_enabled, 0);
        chk("R10 rts_n", rts_n, 0);
        chk("R10 irq", irq, 0);
        chk("R10 overrun", st_overrun, 0);

        // R9: ignored while disabled
        send(0);
        chk("R9 disabled ignores char", st_ready, 0);
        cmd_enable = 1; step();
        chk("R9 enable", rx_enabled, 1);

        // R1 R2 R3: fill and drain both depths
        for (int dp = 0; dp < 2; dp++) begin
            int d;
            d = dp ? 16 : 8;
            cfg_deep = dp[0];
            cfg_irq_full = dp[0];
            for (int i = 0; i < d; i++) begin
                send(i);
                chk("R2 ready", st_ready, 1);
                chk("R1 full at depth", st_full, (i == d - 1) ? 1 : 0);
                chk("R2 irq source", irq, dp ? ((i == d - 1) ? 1 : 0) : 1);
            end
            for (int i = 0; i < d; i++) begin
                chk("R3 head data", rd_char, fdata(i));
                chk("R3 head flags", fl(), fflags(i));
                pop();
            end
            chk("R3 empty ready", st_ready, 0);
            chk("R3 empty flags", fl(), 0);
        end
        cfg_deep = 0; cfg_irq_full = 0;

        // R5: read on empty has no effect
        pop();
        chk("R5 empty read", st_ready, 0);

        // R4: accumulated flags
        cfg_block_err = 1;
        cmd_err_reset = 1; step();
        for (int i = 20; i < 26; i++) send(i);
        begin
            int acc;
            acc = 0;
            for (int j = 20; j < 26; j++) begin
                acc = acc | fflags(j);
                chk("R4 accumulated flags", fl(), acc);
                pop();
            end
            chk("R4 flags kept when empty", fl(), acc);
        end
        cmd_err_reset = 1; step();
        chk("R4 error reset clears", fl(), 0);
        cfg_block_err = 0;

        // R6 R7: holding stage and overrun
        for (int i = 40; i < 48; i++) send(i);
        send(48);
        chk("R6 full with held", st_full, 1);
        chk("R7 no overrun yet", st_overrun, 0);
        start_bit = 1; step();
        chk("R7 overrun on start", st_overrun, 1);
        send(49);
        chk("R7 head unchanged", rd_char, fdata(40));
        pop();
        chk("R6 held moves in on read", st_full, 1);
        for (int i = 41; i < 48; i++) begin
            chk("R7 order", rd_char, fdata(i));
            pop();
        end
        chk("R7 replaced char last", rd_char, fdata(49));
        pop();
        chk("R7 drained", st_ready, 0);
        chk("R7 overrun sticky", st_overrun, 1);
        cmd_err_reset = 1; step();
        chk("R4 error reset clears overrun", st_overrun, 0);

        // R11: push and pop in one cycle
        for (int i = 60; i < 63; i++) send(i);
        rd_data = 1; send(63);
        for (int i = 61; i < 64; i++) begin
            chk("R11 order", rd_char, fdata(i));
            chk("R11 ready", st_ready, 1);
            pop();
        end
        chk("R11 count kept", st_ready, 0);

        // R8: automatic request-to-send
        cfg_auto_rts = 1;
        for (int i = 70; i < 78; i++) send(i);
        chk("R8 rts idle", rts_n, 0);
        start_bit = 1; step();
        chk("R8 rts raised", rts_n, 1);
        pop();
        chk("R8 rts released", rts_n, 0);
        start_bit = 1; step();
        chk("R8 rts not full", rts_n, 0);
        for (int i = 0; i < 7; i++) pop();
        cfg_auto_rts = 0;
        chk("R8 drained", st_ready, 0);

        // R9: disable drops held char, keeps queue
        for (int i = 80; i < 88; i++) send(i);
        send(88);
        cmd_disable = 1; step();
        chk("R9 disabled", rx_enabled, 0);
        chk("R9 data kept", st_full, 1);
        send(89);
        for (int i = 80; i < 88; i++) begin
            chk("R9 readable", rd_char, fdata(i));
            pop();
        end
        chk("R9 held dropped", st_ready, 0);
        cmd_enable = 1; step();
        send(90);
        chk("R9 resumes", rd_char, fdata(90));

        // R10: receiver reset
        cmd_rx_reset = 1; step();
        chk("R10 cleared", st_ready, 0);
        chk("R10 disabled", rx_enabled, 0);
        send(91);
        chk("R10 no accept", st_ready, 0);
        cmd_enable = 1; step();
        send(92);
        chk("R10 after enable", rd_char, fdata(92));
        pop();

        summary();
    end

endmodule